// File: doc/BRIEF.md
# Cascaded Two-Stage Timer Prescaler

This block turns the system clock into the two timing references of a loop-based timer engine. The first stage divides the clock by a linear factor from 1 to 64 and produces the fine-grain tick. The second stage counts fine-grain ticks and divides them by a power of two from 1 to 128. The result is the loop-start tick that begins each pass of the timer program. Both factors come from one configuration word. A write to that word is held and only takes effect at the next loop boundary, so a loop never ends early.

Each loop therefore offers hr × lr system-clock time slots. The block reports the index of the current slot. A program-done input tells the block that the engine has finished its pass. If a loop boundary arrives before the engine has reported completion since the previous boundary, the block sets a sticky overflow flag. The flag stays set until software clears it with a write-one-to-clear pulse.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset both factors are /1, so `hr_tick` and `loop_tick` are high in every cycle, `slot_idx` is 0 and `ovf_flag` is 0.
- R2: The fine divide code sits in bits [5:0] of the configuration word, and the factor is code+1. `hr_tick` is high for one cycle out of every code+1 cycles, and the pulse falls on the last cycle of each group.
- R3: The loop divide code sits in bits [10:8], and the factor is 2^code. `loop_tick` is high for one cycle out of every (hr factor × lr factor) cycles, and only in a cycle where `hr_tick` is also high.
- R4: `slot_idx` is 0 in the cycle after a loop tick and rises by one each cycle. It reads hr × lr − 1 in the cycle of the next loop tick.
- R5: A configuration write takes effect at the first loop tick that follows the write cycle. The loop that is running completes at its old length.
- R6: Bits of the configuration word outside [5:0] and [10:8] have no effect on either tick or on the slot index.
- R7: In a loop-tick cycle, if `prog_done` has been low in every cycle since the previous loop tick (the current cycle included), `ovf_flag` is high from the next cycle on. It is never set before that boundary.
- R8: `ovf_flag` stays high until `ovf_clr` is pulsed. It then reads 0 from the next cycle. If a new overflow is detected in the same cycle as the clear, the set wins.
- R9: A single-cycle `prog_done` anywhere in a loop, the loop-tick cycle included, prevents the overflow at that loop's end. The done status does not carry into the following loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (fine code [5:0], loop code [10:8]) |
| prog_done | input | 1 | Engine reports its pass is complete |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| hr_tick | output | 1 | Fine-grain tick, one cycle wide |
| loop_tick | output | 1 | Loop-start tick, one cycle wide |
| slot_idx | output | 13 | Time-slot index within the current loop |
| ovf_flag | output | 1 | Sticky program-overflow flag |

## Verification
Both ticks are decoded from counter state, so they are due in the same cycle as the count they describe. The bench reads them at the falling edge of that cycle. The slot index and the overflow flag are registered, so they change one cycle after a loop tick. Every check on them is made at the falling edge one cycle after the tick that caused the change. A configuration write is checked against the first tick that follows it: the bench counts cycles from a known loop start and expects the old length to finish before it measures the new one.

// File: rtl/tps_pkg.sv
package tps_pkg;
   // Span of the loop counter: the largest power-of-two factor minus one.
   function automatic int unsigned loop_cnt_width(input int unsigned lr_w);
      return (32'd1 << lr_w) - 32'd1;
   endfunction

   // Width that can hold every slot index of the longest loop.
   function automatic int unsigned slot_width(input int unsigned hr_w,
                                              input int unsigned lr_w);
      return hr_w + loop_cnt_width(lr_w);
   endfunction

   typedef enum logic [1:0] {
      OVF_IDLE  = 2'b00,
      OVF_SET   = 2'b01,
      OVF_CLEAR = 2'b10
   } ovf_op_e;
endpackage

// File: rtl/tps_cfg_hold.sv
module tps_cfg_hold #(
   parameter int unsigned CFG_W  = 16,
   parameter int unsigned HR_W   = 6,
   parameter int unsigned LR_W   = 3,
   parameter int unsigned HR_LSB = 0,
   parameter int unsigned LR_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              loop_tick,
   output logic [HR_W-1:0]   hr_code,
   output logic [LR_W-1:0]   lr_code
);
   logic [HR_W-1:0] pend_hr;
   logic [LR_W-1:0] pend_lr;

   // Staging registers follow every write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_hr <= '0;
         pend_lr <= '0;
      end else if (cfg_we) begin
         pend_hr <= cfg_wdata[HR_LSB +: HR_W];
         pend_lr <= cfg_wdata[LR_LSB +: LR_W];
      end
   end

   // Active factors change only on a loop boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hr_code <= '0;
         lr_code <= '0;
      end else if (loop_tick) begin
         hr_code <= pend_hr;
         lr_code <= pend_lr;
      end
   end
endmodule

// File: rtl/tps_hr_stage.sv
module tps_hr_stage #(
   parameter int unsigned HR_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HR_W-1:0] hr_code,
   output logic            hr_tick
);
   logic [HR_W-1:0] cnt_q;

   assign hr_tick = (cnt_q == hr_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (hr_tick) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tps_lr_stage.sv
module tps_lr_stage
   import tps_pkg::*;
#(
   parameter int unsigned LR_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hr_tick,
   input  logic [LR_W-1:0] lr_code,
   output logic            loop_tick
);
   localparam int unsigned CNT_W = loop_cnt_width(LR_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   // Terminal count 2^code - 1 as a thermometer mask, one bit per stage.
   for (genvar i = 0; i < CNT_W; i++) begin : g_term
      assign term[i] = (lr_code > LR_W'(i));
   end

   assign loop_tick = hr_tick && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (loop_tick) cnt_q <= '0;
      else if (hr_tick)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tps_ovf_mon.sv
module tps_ovf_mon
   import tps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic loop_tick,
   input  logic prog_done,
   input  logic ovf_clr,
   output logic ovf_flag
);
   logic    done_seen;
   ovf_op_e op;

   always_comb begin
      if (loop_tick && !(done_seen || prog_done)) op = OVF_SET;
      else if (ovf_clr)                           op = OVF_CLEAR;
      else                                        op = OVF_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         done_seen <= 1'b0;
      else if (loop_tick) done_seen <= 1'b0;
      else if (prog_done) done_seen <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_flag <= 1'b0;
      else begin
         case (op)
            OVF_SET:   ovf_flag <= 1'b1;
            OVF_CLEAR: ovf_flag <= 1'b0;
            default:   ovf_flag <= ovf_flag;
         endcase
      end
   end
endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top
   import tps_pkg::*;
#(
   parameter int unsigned CFG_W  = 16,
   parameter int unsigned HR_W   = 6,
   parameter int unsigned LR_W   = 3,
   parameter int unsigned HR_LSB = 0,
   parameter int unsigned LR_LSB = 8,
   parameter int unsigned SLOT_W = slot_width(HR_W, LR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              prog_done,
   input  logic              ovf_clr,
   output logic              hr_tick,
   output logic              loop_tick,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              ovf_flag
);
   localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

   // Elaboration-time parameter checks.
   if (HR_W < 1 || HR_W > 16)
      $error("tmr_prescale_top: HR_W out of range");
   if (LR_W < 1 || LR_W > 4)
      $error("tmr_prescale_top: LR_W out of range");
   if (HR_LSB + HR_W > CFG_W || LR_LSB + LR_W > CFG_W)
      $error("tmr_prescale_top: field exceeds configuration word");
   if (!(HR_LSB + HR_W <= LR_LSB || LR_LSB + LR_W <= HR_LSB))
      $error("tmr_prescale_top: configuration fields overlap");
   if (SLOT_W < slot_width(HR_W, LR_W))
      $error("tmr_prescale_top: SLOT_W too narrow");

   logic [HR_W-1:0] hr_code;
   logic [LR_W-1:0] lr_code;

   tps_cfg_hold #(
      .CFG_W (CFG_W),
      .HR_W  (HR_W),
      .LR_W  (LR_W),
      .HR_LSB(HR_LSB),
      .LR_LSB(LR_LSB)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .loop_tick(loop_tick),
      .hr_code  (hr_code),
      .lr_code  (lr_code)
   );

   tps_hr_stage #(.HR_W(HR_W)) u_hr (
      .clk    (clk),
      .rst_n  (rst_n),
      .hr_code(hr_code),
      .hr_tick(hr_tick)
   );

   tps_lr_stage #(.LR_W(LR_W)) u_lr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hr_tick  (hr_tick),
      .lr_code  (lr_code),
      .loop_tick(loop_tick)
   );

   tps_ovf_mon u_ovf (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop_tick(loop_tick),
      .prog_done(prog_done),
      .ovf_clr  (ovf_clr),
      .ovf_flag (ovf_flag)
   );

   // Slot index: restarts after each loop tick, saturates at full scale.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   slot_idx <= '0;
      else if (loop_tick)           slot_idx <= '0;
      else if (slot_idx != SLOT_MAX) slot_idx <= slot_idx + 1'b1;
   end
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
   parameter int unsigned SLOT_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hr_tick,
   input logic              loop_tick,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              ovf_flag,
   input logic              ovf_clr
);
   p_loop_on_hr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_tick |-> hr_tick);

   p_slot_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loop_tick |=> (slot_idx == '0));

   p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_tick && slot_idx != '1) |=> (slot_idx == $past(slot_idx) + 1'b1));

   p_ovf_only_at_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(loop_tick));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !loop_tick) |=> !ovf_flag);
endmodule

bind tmr_prescale_top tps_checker #(.SLOT_W(SLOT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hr_tick  (hr_tick),
   .loop_tick(loop_tick),
   .slot_idx (slot_idx),
   .ovf_flag (ovf_flag),
   .ovf_clr  (ovf_clr)
);

// File: tb/tb_tmr_prescale_top.sv
`timescale 1ns/1ps
module tb_tmr_prescale_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        prog_done = 1'b1;
   logic        ovf_clr = 1'b0;
   logic        hr_tick, loop_tick, ovf_flag;
   logic [12:0] slot_idx;

   int tests = 0;
   int fails = 0;
   bit done_run = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   tmr_prescale_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .prog_done(prog_done), .ovf_clr(ovf_clr), .hr_tick(hr_tick),
      .loop_tick(loop_tick), .slot_idx(slot_idx), .ovf_flag(ovf_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Caller sits at a falling edge. Writes the word, then stops at the
   // falling edge of the loop tick that activates it.
   task automatic apply_cfg(input logic [15:0] word);
      cfg_wdata = word;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
      while (!loop_tick) @(negedge clk);
   endtask

   task automatic next_tick();
      do @(negedge clk); while (!loop_tick);
   endtask

   // Walks one full loop right after a loop tick and compares every cycle.
   task automatic measure_loop(input int hr, input int lr, input string tag);
      int ts = hr * lr;
      int e_hr = 0, e_lp = 0, e_sl = 0;
      for (int n = 1; n <= ts; n++) begin
         @(negedge clk);
         if (hr_tick !== ((n % hr) == 0)) e_hr++;
         if (loop_tick !== (n == ts)) e_lp++;
         if (slot_idx !== 13'(n - 1)) e_sl++;
      end
      check(e_hr == 0, {"R2 fine tick ", tag}, e_hr, 0);
      check(e_lp == 0, {"R3 loop tick ", tag}, e_lp, 0);
      check(e_sl == 0, {"R4 slot index ", tag}, e_sl, 0);
   endtask

   function automatic logic [15:0] mk_word(input int hc, input int lc, input bit junk);
      logic [15:0] w = '0;
      w[5:0]  = 6'(hc);
      w[10:8] = 3'(lc);
      if (junk) begin
         w[7:6]   = 2'b11;
         w[15:11] = 5'b10110;
      end
      return w;
   endfunction

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(hr_tick === 1'b1,    "R1 reset fine tick", int'(hr_tick), 1);
      check(loop_tick === 1'b1,  "R1 reset loop tick", int'(loop_tick), 1);
      check(slot_idx === 13'd0,  "R1 reset slot", int'(slot_idx), 0);
      check(ovf_flag === 1'b0,   "R1 reset overflow", int'(ovf_flag), 0);
      begin
         int e = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!(hr_tick && loop_tick && slot_idx == 0)) e++;
         end
         check(e == 0, "R1 divide-by-one every cycle", e, 0);
      end

      // Every fine code with the two smallest loop codes; odd codes carry
      // junk in the unused bits (R6).
      for (int h = 0; h < 64; h++) begin
         for (int l = 0; l < 2; l++) begin
            apply_cfg(mk_word(h, l, h[0]));
            measure_loop(h + 1, 1 << l, h[0] ? "R6 junk bits" : "sweep");
         end
      end
      // Every loop code at the fine extremes.
      for (int l = 2; l < 8; l++) begin
         apply_cfg(mk_word(0, l, 1'b0));
         measure_loop(1, 1 << l, "lr sweep hr1");
         apply_cfg(mk_word(1, l, 1'b1));
         measure_loop(2, 1 << l, "R6 lr sweep hr2");
         apply_cfg(mk_word(63, l, 1'b0));
         measure_loop(64, 1 << l, "lr sweep hr64");
      end
      check(ovf_flag === 1'b0, "R9 no overflow while done held", int'(ovf_flag), 0);

      // R5: write in the middle of an 8-slot loop.
      apply_cfg(mk_word(3, 1, 1'b0));
      measure_loop(4, 2, "pre R5");
      repeat (3) @(negedge clk);
      cfg_wdata = mk_word(1, 0, 1'b0);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      begin
         int k = 4;
         while (!loop_tick) begin @(negedge clk); k++; end
         check(k == 8, "R5 running loop keeps old length", k, 8);
         check(slot_idx === 13'd7, "R5 last slot of old loop", int'(slot_idx), 7);
      end
      measure_loop(2, 1, "R5 new config");

      // Overflow scenarios on a 6-slot loop.
      apply_cfg(mk_word(2, 1, 1'b0));
      measure_loop(3, 2, "ovf setup");
      prog_done = 1'b0;
      next_tick();
      check(ovf_flag === 1'b0, "R7 not set before boundary", int'(ovf_flag), 0);
      @(negedge clk);
      check(ovf_flag === 1'b1, "R7 set after missed boundary", int'(ovf_flag), 1);
      prog_done = 1'b1;
      next_tick();
      @(negedge clk);
      check(ovf_flag === 1'b1, "R8 flag sticky", int'(ovf_flag), 1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check(ovf_flag === 1'b0, "R8 cleared by write-one", int'(ovf_flag), 0);
      prog_done = 1'b0;
      @(negedge clk);
      prog_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0;
      next_tick();
      @(negedge clk);
      check(ovf_flag === 1'b0, "R9 mid-loop done pulse", int'(ovf_flag), 0);
      next_tick();
      prog_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0;
      check(ovf_flag === 1'b0, "R9 done in tick cycle", int'(ovf_flag), 0);
      next_tick();
      @(negedge clk);
      check(ovf_flag === 1'b1, "R9 done does not carry over", int'(ovf_flag), 1);
      next_tick();
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check(ovf_flag === 1'b1, "R8 set wins over clear", int'(ovf_flag), 1);
      prog_done = 1'b1;
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      @(negedge clk);
      check(ovf_flag === 1'b0, "R8 final clear", int'(ovf_flag), 0);

      done_run = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_run) begin
         tests++;
         fails++;
         $display("FAIL watchdog R1-run actual=190000 cycles expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule